// File: doc/BRIEF.md
# Serial Memory Hold and Write-Protect Front-End

This block is the slave-side serial front-end of a flash-style memory that uses a four-wire serial bus. It takes chip select, serial clock, serial data in, a hold pin and a write-protect pin, and it drives serial data out together with an output enable. A system clock at least four times faster than the serial clock oversamples every pin through two-flop synchronisers. All serial edges are found on the synchronised signals.

The block shifts in a command byte and, where the command needs one, a data byte. It keeps an 8-bit status register with a lock bit and two protect bits. It returns that register on the read-status command. The hold pin pauses a transfer part way through and keeps the bit position. Hold starts and ends only while the serial clock is low. A status write is refused when the write-protect pin is low and the lock bit is set.

Top module: `spi_hold_wp_frontend`

## Requirements
- R1: Bus mode 0: SI is sampled on rising SCK, MSB first. Opcode 0x01 followed by one data byte updates the status register when CS# rises after exactly 16 counted clocks.
- R2: A write frame of 01h with any count other than 16 rising clocks before CS# rises leaves the status register unchanged.
- R3: Opcode 0x05 returns the status register on SO, MSB first. The first bit is driven after the 8th falling edge and the byte repeats while clocking continues. so_oe is 1 only in this output phase and 0 while a command byte or write data is being shifted.
- R4: Status layout: bit 7 is the lock bit and bits 3 and 2 are the protect bits. All other bits always read 0, and the register resets to 0x00.
- R5: With WP# high, a status write always takes effect, whatever the lock bit holds.
- R6: With WP# low and the lock bit 0, a status write takes effect and wrsr_rejected stays low.
- R7: With WP# low and the lock bit 1, a status write is refused, the register is unchanged, and wrsr_rejected pulses for exactly one system clock.
- R8: Hold can only be entered while CS# is low. With CS# high, a low HOLD# leaves hold_active at 0.
- R9: HOLD# falling while SCK is low sets hold_active within 4 system clocks. HOLD# falling while SCK is high leaves hold_active at 0 until SCK goes low.
- R10: HOLD# rising while SCK is low clears hold_active within 4 system clocks. HOLD# rising while SCK is high leaves hold_active at 1 until SCK goes low.
- R11: During hold, so_oe is 0 and SCK and SI transitions are ignored. After hold ends, the transfer resumes at the same bit position.
- R12: CS# going high during hold clears hold and the partial transfer. A following complete frame, sent with HOLD# high, is decoded from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Hold request, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so |
| hold_active | output | 1 | Registered hold state |
| wrsr_rejected | output | 1 | One-cycle pulse when a status write is refused |

## Verification
The hardest cases to reach are hold entry and hold exit while SCK is high. The bench must stop part way through a bit, after a rising edge has been counted, and move the hold pin before the matching falling edge arrives. It does this with hand-sequenced pin steps inside a read-status transfer. It drives extra clock pulses during hold and then checks that the returned status byte still comes out whole. This shows that the deferred entry edge counted and the deferred exit edge did not.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    localparam int BYTE_W     = 8;
    localparam int FRAME_BITS = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] OP_WRITE_STAT = 8'h01;
    localparam logic [BYTE_W-1:0] OP_READ_STAT  = 8'h05;

    localparam int LOCK_BIT  = 7;
    localparam int PROT1_BIT = 3;
    localparam int PROT0_BIT = 2;

    localparam logic [BYTE_W-1:0] STAT_MASK =
        (BYTE_W'(1) << LOCK_BIT) | (BYTE_W'(1) << PROT1_BIT) | (BYTE_W'(1) << PROT0_BIT);

    typedef struct packed {
        logic cs_n;
        logic sck;
        logic si;
        logic hold_n;
        logic wp_n;
    } pin_t;

    localparam pin_t PIN_IDLE = '{cs_n: 1'b1, sck: 1'b0, si: 1'b0, hold_n: 1'b1, wp_n: 1'b1};

    typedef struct packed {
        logic sck_rise;
        logic sck_fall;
        logic sck_low;
        logic cs_rise;
        logic cs_idle;
    } evt_t;

    function automatic logic stat_write_allowed(input logic wp_n_lvl, input logic [BYTE_W-1:0] stat);
        return wp_n_lvl | ~stat[LOCK_BIT];
    endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int                WIDTH   = 5,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/spi_fe_events.sv
module spi_fe_events
    import spi_fe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sck_s,
    input  logic cs_n_s,
    output evt_t ev
);
    logic sck_prev;
    logic cs_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev <= 1'b0;
            cs_prev  <= 1'b1;
        end else begin
            sck_prev <= sck_s;
            cs_prev  <= cs_n_s;
        end
    end

    always_comb begin
        ev.sck_rise = sck_s & ~sck_prev;
        ev.sck_fall = ~sck_s & sck_prev;
        ev.sck_low  = ~sck_s;
        ev.cs_rise  = cs_n_s & ~cs_prev;
        ev.cs_idle  = cs_n_s;
    end
endmodule

// File: rtl/spi_fe_hold.sv
module spi_fe_hold (
    input  logic clk,
    input  logic rst,
    input  logic sck_low,
    input  logic cs_idle,
    input  logic hold_n_s,
    output logic hold_active
);
    always_ff @(posedge clk) begin
        if (rst)          hold_active <= 1'b0;
        else if (cs_idle) hold_active <= 1'b0;
        else if (sck_low) hold_active <= ~hold_n_s;
    end

    AST_HOLD_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        cs_idle |=> !hold_active); // R8

    AST_HOLD_WAITS_SCK_LOW: assert property (@(posedge clk) disable iff (rst)
        (!sck_low && !cs_idle) |=> $stable(hold_active)); // R10

    AST_HOLD_ENTRY_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_active) |-> $past(sck_low)); // R9
endmodule

// File: rtl/spi_fe_core.sv
module spi_fe_core
    import spi_fe_pkg::*;
#(
    parameter int W     = BYTE_W,
    parameter int FRAME = FRAME_BITS
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_rise,
    input  logic sck_fall,
    input  logic cs_rise,
    input  logic cs_idle,
    input  logic si_s,
    input  logic wp_n_s,
    input  logic hold_active,
    output logic so,
    output logic so_oe,
    output logic wrsr_rejected
);
    localparam int                CNT_W   = $clog2(FRAME + 2);
    localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0]  CNT_CMD = CNT_W'(W - 1);
    localparam logic [CNT_W-1:0]  CNT_END = CNT_W'(FRAME);

    logic [CNT_W-1:0] bit_cnt;
    logic [W-1:0]     in_sr;
    logic [W-1:0]     cmd_q;
    logic [W-1:0]     out_sr;
    logic [W-1:0]     status_q;
    logic             rd_en;
    logic             out_on;
    logic             so_q;
    logic             rej_q;

    logic             rise_g;
    logic             fall_g;
    logic [W-1:0]     in_next;

    assign rise_g  = sck_rise & ~hold_active & ~cs_idle;
    assign fall_g  = sck_fall & ~hold_active & ~cs_idle;
    assign in_next = {in_sr[W-2:0], si_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            in_sr    <= '0;
            cmd_q    <= '0;
            out_sr   <= '0;
            status_q <= '0;
            rd_en    <= 1'b0;
            out_on   <= 1'b0;
            so_q     <= 1'b0;
            rej_q    <= 1'b0;
        end else begin
            rej_q <= 1'b0;
            if (cs_rise && bit_cnt == CNT_END && cmd_q == OP_WRITE_STAT) begin
                if (stat_write_allowed(wp_n_s, status_q)) status_q <= in_sr & STAT_MASK;
                else                                      rej_q    <= 1'b1;
            end
            if (cs_idle) begin
                bit_cnt <= '0;
                in_sr   <= '0;
                cmd_q   <= '0;
                rd_en   <= 1'b0;
                out_on  <= 1'b0;
                so_q    <= 1'b0;
            end else begin
                if (rise_g) begin
                    in_sr <= in_next;
                    if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == CNT_CMD) begin
                        cmd_q <= in_next;
                        if (in_next == OP_READ_STAT) begin
                            rd_en  <= 1'b1;
                            out_sr <= status_q;
                        end
                    end
                end
                if (fall_g && rd_en) begin
                    so_q   <= out_sr[W-1];
                    out_sr <= {out_sr[W-2:0], out_sr[W-1]};
                    out_on <= 1'b1;
                end
            end
        end
    end

    assign so            = so_q;
    assign so_oe         = out_on & ~hold_active;
    assign wrsr_rejected = rej_q;

    AST_POSITION_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (hold_active && !cs_idle) |=> $stable(bit_cnt)); // R11

    AST_LOCKED_STATUS: assert property (@(posedge clk) disable iff (rst)
        (!wp_n_s && status_q[LOCK_BIT]) |=> $stable(status_q)); // R7

    AST_REJECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wrsr_rejected |=> !wrsr_rejected); // R7

    AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (status_q & ~STAT_MASK) == '0); // R4

    AST_WRITE_NEEDS_FULL_FRAME: assert property (@(posedge clk) disable iff (rst)
        !cs_rise |=> $stable(status_q)); // R2
endmodule

// File: rtl/spi_hold_wp_frontend.sv
module spi_hold_wp_frontend
    import spi_fe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic so,
    output logic so_oe,
    output logic hold_active,
    output logic wrsr_rejected
);
    localparam int PIN_W = $bits(pin_t);

    pin_t pins_raw;
    pin_t pins_s;
    evt_t ev;

    assign pins_raw = '{cs_n: cs_n, sck: sck, si: si, hold_n: hold_n, wp_n: wp_n};

    spi_fe_sync #(
        .WIDTH   (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pins_raw),
        .q_sync  (pins_s)
    );

    spi_fe_events u_events (
        .clk    (clk),
        .rst    (rst),
        .sck_s  (pins_s.sck),
        .cs_n_s (pins_s.cs_n),
        .ev     (ev)
    );

    spi_fe_hold u_hold (
        .clk         (clk),
        .rst         (rst),
        .sck_low     (ev.sck_low),
        .cs_idle     (ev.cs_idle),
        .hold_n_s    (pins_s.hold_n),
        .hold_active (hold_active)
    );

    spi_fe_core u_core (
        .clk           (clk),
        .rst           (rst),
        .sck_rise      (ev.sck_rise),
        .sck_fall      (ev.sck_fall),
        .cs_rise       (ev.cs_rise),
        .cs_idle       (ev.cs_idle),
        .si_s          (pins_s.si),
        .wp_n_s        (pins_s.wp_n),
        .hold_active   (hold_active),
        .so            (so),
        .so_oe         (so_oe),
        .wrsr_rejected (wrsr_rejected)
    );
endmodule

// File: tb/spi_hold_wp_frontend_tb.sv
module spi_hold_wp_frontend_tb_top;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic so, so_oe, hold_active, wrsr_rejected;

    int tests = 0;
    int fails = 0;
    int rej_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_hold_wp_frontend dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe),
        .hold_active(hold_active), .wrsr_rejected(wrsr_rejected)
    );

    always @(negedge clk) if (!rst && wrsr_rejected) rej_cnt++;

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic xfer_bit(input logic b, output logic o);
        si = b;
        wclk(HALF);
        o = so;
        sck = 1'b1;
        wclk(HALF);
        sck = 1'b0;
    endtask

    task automatic cs_start();
        cs_n = 1'b0;
        wclk(HALF);
    endtask

    task automatic cs_end();
        wclk(HALF);
        cs_n = 1'b1;
        wclk(HALF);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic [7:0] o);
        for (int i = 7; i >= 0; i--) xfer_bit(v[i], o[i]);
    endtask

    task automatic wr_stat(input logic [7:0] v);
        logic [7:0] d;
        cs_start();
        send_byte(8'h01, d);
        send_byte(v, d);
        cs_end();
    endtask

    task automatic rd_stat(output logic [7:0] v);
        logic [7:0] d;
        cs_start();
        send_byte(8'h05, d);
        send_byte(8'h00, v);
        cs_end();
    endtask

    task automatic t_reset();
        logic [7:0] r;
        chk("R4", "hold_active after reset", hold_active, 0);
        chk("R3", "so_oe after reset", so_oe, 0);
        chk("R7", "wrsr_rejected after reset", wrsr_rejected, 0);
        rd_stat(r);
        chk("R4", "status reset value", r, 8'h00);
    endtask

    task automatic t_write_read();
        logic [7:0] r, d;
        wp_n = 1'b1;
        wr_stat(8'h0C);
        rd_stat(r);
        chk("R1", "write 0C", r, 8'h0C);
        wr_stat(8'hFF);
        rd_stat(r);
        chk("R4", "unused bits masked", r, 8'h8C);
        wr_stat(8'h04);
        rd_stat(r);
        chk("R5", "WP high overrides lock", r, 8'h04);
        cs_start();
        send_byte(8'h05, d);
        chk("R3", "so_oe low in command phase", so_oe, 0);
        wclk(HALF);
        chk("R3", "so_oe high in output phase", so_oe, 1);
        send_byte(8'h00, r);
        send_byte(8'h00, d);
        cs_end();
        chk("R3", "first output byte", r, 8'h04);
        chk("R3", "repeated output byte", d, 8'h04);
        cs_start();
        send_byte(8'h01, d);
        wclk(HALF);
        chk("R3", "so_oe low during write data", so_oe, 0);
        send_byte(8'h04, d);
        cs_end();
    endtask

    task automatic t_frame_len();
        logic [7:0] r, d;
        logic b;
        cs_start();
        send_byte(8'h01, d);
        for (int i = 0; i < 7; i++) xfer_bit(1'b0, b);
        cs_end();
        rd_stat(r);
        chk("R2", "15-bit write ignored", r, 8'h04);
        cs_start();
        send_byte(8'h01, d);
        send_byte(8'h08, d);
        xfer_bit(1'b0, b);
        cs_end();
        rd_stat(r);
        chk("R2", "17-bit write ignored", r, 8'h04);
    endtask

    task automatic t_protect();
        logic [7:0] r;
        int base;
        wp_n = 1'b1;
        wr_stat(8'h80);
        wp_n = 1'b0;
        base = rej_cnt;
        wr_stat(8'h0C);
        rd_stat(r);
        chk("R7", "locked write refused", r, 8'h80);
        chk("R7", "reject pulse count", rej_cnt - base, 1);
        wp_n = 1'b1;
        wr_stat(8'h00);
        wp_n = 1'b0;
        base = rej_cnt;
        wr_stat(8'h08);
        rd_stat(r);
        chk("R6", "unlocked write with WP low", r, 8'h08);
        wr_stat(8'h8C);
        rd_stat(r);
        chk("R6", "set lock with WP low", r, 8'h8C);
        chk("R6", "no reject pulse", rej_cnt - base, 0);
        wp_n = 1'b1;
    endtask

    task automatic t_hold_sck_low();
        logic [7:0] r, d;
        logic b;
        cs_start();
        for (int i = 0; i < 4; i++) xfer_bit(1'b0, b);
        hold_n = 1'b0;
        wclk(4);
        chk("R9", "hold entry with SCK low", hold_active, 1);
        si = 1'b1;
        for (int i = 0; i < 3; i++) begin
            sck = 1'b1; wclk(HALF); sck = 1'b0; wclk(HALF);
        end
        chk("R11", "hold kept over SCK pulses", hold_active, 1);
        hold_n = 1'b1;
        wclk(4);
        chk("R10", "hold exit with SCK low", hold_active, 0);
        xfer_bit(1'b0, b); xfer_bit(1'b1, b); xfer_bit(1'b0, b); xfer_bit(1'b1, b);
        send_byte(8'h00, r);
        cs_end();
        chk("R11", "command resumed after hold", r, 8'h8C);
        d = 8'h00;
    endtask

    task automatic t_hold_sck_high();
        logic [7:0] r, d;
        cs_start();
        send_byte(8'h05, d);
        xfer_bit(1'b0, r[7]);
        xfer_bit(1'b0, r[6]);
        si = 1'b0;
        wclk(HALF);
        r[5] = so;
        sck = 1'b1;
        wclk(HALF);
        hold_n = 1'b0;
        wclk(6);
        chk("R9", "hold deferred while SCK high", hold_active, 0);
        sck = 1'b0;
        wclk(4);
        chk("R9", "hold entered at SCK low", hold_active, 1);
        chk("R11", "so_oe off in hold", so_oe, 0);
        si = 1'b1;
        for (int i = 0; i < 2; i++) begin
            sck = 1'b1; wclk(HALF); sck = 1'b0; wclk(HALF);
        end
        sck = 1'b1;
        wclk(HALF);
        hold_n = 1'b1;
        wclk(6);
        chk("R10", "exit deferred while SCK high", hold_active, 1);
        sck = 1'b0;
        wclk(4);
        chk("R10", "exit at SCK low", hold_active, 0);
        chk("R11", "so_oe back after hold", so_oe, 1);
        for (int i = 4; i >= 0; i--) xfer_bit(1'b0, r[i]);
        cs_end();
        chk("R11", "read byte across hold", r, 8'h8C);
    endtask

    task automatic t_cs_during_hold();
        logic [7:0] r, d;
        logic b;
        cs_n = 1'b1;
        hold_n = 1'b0;
        wclk(6);
        chk("R8", "no hold with CS high", hold_active, 0);
        hold_n = 1'b1;
        wclk(4);
        cs_start();
        send_byte(8'h01, d);
        for (int i = 0; i < 4; i++) xfer_bit(1'b0, b);
        hold_n = 1'b0;
        wclk(4);
        chk("R12", "hold before CS release", hold_active, 1);
        cs_n = 1'b1;
        wclk(6);
        chk("R12", "CS high clears hold", hold_active, 0);
        hold_n = 1'b1;
        wclk(HALF);
        rd_stat(r);
        chk("R12", "partial write discarded", r, 8'h8C);
        wr_stat(8'h08);
        rd_stat(r);
        chk("R12", "frame after reset decoded", r, 8'h08);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        wclk(5);
        rst = 1'b0;
        wclk(5);
        t_reset();
        t_write_read();
        t_frame_len();
        t_protect();
        t_hold_sck_low();
        t_hold_sck_high();
        t_cs_during_hold();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule